// File: doc/BRIEF.md
# Modulation-Mode Buffer Transfer Controller

This block sits beside a three-phase waveform generator. It decides, each cycle, whether the phase buffer registers are copied into the output shift register and whether the dead-time timer is started. It produces two strobes for the logic downstream: `xfer_o` and `dt_trig_o`.

A transfer trigger can come from three sources: a timer underflow, a software write of 1 to a trigger bit, or a write to the timer register while a qualifying enable is set. What a trigger does depends on the modulation mode. In triangular mode, fresh buffer contents are moved once, on the first trigger after a buffer write. In sawtooth mode, every trigger moves the buffers and also starts the dead-time timer. In both modes, the falling edge of any of the one-shot pulses starts the dead-time timer.

Top module: `xfer_ctl_top`

## Requirements
- R1: While `rst_ni` is low, `xfer_o` and `dt_trig_o` are 0, the internal pending flag is cleared and the stored one-shot levels are cleared.
- R2: A trigger in cycle k is any of `uflow_i`, (`sw_trig_wr_i` and `sw_trig_wdata_i`), or (`tmr_wr_i` and `tmr_trig_en_i`). When a transfer is due, `xfer_o` is 1 in cycle k+1.
- R3: With `saw_mode_i`=0, a trigger produces a transfer only if the pending flag is set. That transfer clears the flag, so later triggers move nothing until some buffer is written again.
- R4: Any bit of `buf_wr_i` sets the pending flag, and this takes precedence over a clear in the same cycle. A trigger in the same cycle as a buffer write uses the flag value from before that write.
- R5: With `saw_mode_i`=1, every trigger produces a transfer, whatever the pending flag holds, and the pending flag is left unchanged.
- R6: If bit i of `os_pulse_i` was 1 in cycle k-1 and is 0 in cycle k, `dt_trig_o` is 1 in cycle k+1, in either mode. A rising edge on `os_pulse_i` alone produces nothing.
- R7: With `saw_mode_i`=1, every trigger, including the software trigger, also sets `dt_trig_o` in cycle k+1. With `saw_mode_i`=0, triggers never cause `dt_trig_o`.
- R8: `sw_trig_rdata_o` is always 0. A software write with data 0 is not a trigger.
- R9: A timer register write with `tmr_trig_en_i`=0 is not a trigger.
- R10: Triggers and falling edges that coincide in one cycle produce one strobe of one cycle on each affected output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uflow_i | input | 1 | Timer underflow pulse |
| sw_trig_wr_i | input | 1 | Write strobe for the software trigger bit |
| sw_trig_wdata_i | input | 1 | Value written to the software trigger bit |
| sw_trig_rdata_o | output | 1 | Read value of the software trigger bit (always 0) |
| tmr_wr_i | input | 1 | Timer register write strobe |
| tmr_trig_en_i | input | 1 | Enables timer register writes as a trigger |
| buf_wr_i | input | NUM_BUF | Write strobes, one per phase buffer register |
| saw_mode_i | input | 1 | 0 = triangular, 1 = sawtooth |
| os_pulse_i | input | NUM_OS | One-shot pulse levels |
| xfer_o | output | 1 | Buffer-to-shift-register transfer strobe |
| dt_trig_o | output | 1 | Dead-time timer trigger strobe |

## Verification
The bench uses the default parameters: three one-shot channels and two buffer write strobes. With these values, random stimulus reaches falling edges on each channel on its own and on several channels at once, and buffer writes through either strobe, alone or together. Random mode switches leave a pending flag set from one mode and then consume it in the other. Directed cases cover the two orders of a buffer write and a trigger in triangular mode: in the same cycle, and one cycle apart.

// File: rtl/xfer_ctl_pkg.sv
package xfer_ctl_pkg;
  typedef struct packed {
    logic uflow;
    logic sw;
    logic tmr;
  } trig_src_t;

  localparam int unsigned NUM_SRC = $bits(trig_src_t);
endpackage

// File: rtl/xfer_trig_merge.sv
module xfer_trig_merge
  import xfer_ctl_pkg::*;
(
  input  logic uflow_i,
  input  logic sw_wr_i,
  input  logic sw_wdata_i,
  input  logic tmr_wr_i,
  input  logic tmr_en_i,
  output logic trig_o
);
  trig_src_t src;

  always_comb begin
    src.uflow = uflow_i;
    src.sw    = sw_wr_i & sw_wdata_i;
    src.tmr   = tmr_wr_i & tmr_en_i;
  end

  // one strobe however many sources coincide
  assign trig_o = |src;
endmodule

// File: rtl/xfer_os_fall.sv
module xfer_os_fall #(
  parameter int unsigned NUM_OS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_OS-1:0] os_i,
  output logic              any_fall_o
);
  logic [NUM_OS-1:0] fall;

  for (genvar g = 0; g < NUM_OS; g++) begin : g_ch
    logic lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= 1'b0;
      else         lvl_q <= os_i[g];
    end
    assign fall[g] = lvl_q & ~os_i[g];
  end

  assign any_fall_o = |fall;
endmodule

// File: rtl/xfer_pend.sv
module xfer_pend #(
  parameter int unsigned NUM_BUF = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BUF-1:0] buf_wr_i,
  input  logic               clr_i,
  output logic               pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (|buf_wr_i) pend_q <= 1'b1;  // new data wins over a clear
    else if (clr_i)     pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/xfer_ctl_top.sv
module xfer_ctl_top #(
  parameter int unsigned NUM_OS  = 3,
  parameter int unsigned NUM_BUF = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               uflow_i,
  input  logic               sw_trig_wr_i,
  input  logic               sw_trig_wdata_i,
  output logic               sw_trig_rdata_o,
  input  logic               tmr_wr_i,
  input  logic               tmr_trig_en_i,
  input  logic [NUM_BUF-1:0] buf_wr_i,
  input  logic               saw_mode_i,
  input  logic [NUM_OS-1:0]  os_pulse_i,
  output logic               xfer_o,
  output logic               dt_trig_o
);
  logic trig, any_fall, pend, xfer_d, dt_d, tri_xfer;

  xfer_trig_merge u_merge (
    .uflow_i    (uflow_i),
    .sw_wr_i    (sw_trig_wr_i),
    .sw_wdata_i (sw_trig_wdata_i),
    .tmr_wr_i   (tmr_wr_i),
    .tmr_en_i   (tmr_trig_en_i),
    .trig_o     (trig)
  );

  xfer_os_fall #(.NUM_OS(NUM_OS)) u_fall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .os_i       (os_pulse_i),
    .any_fall_o (any_fall)
  );

  assign tri_xfer = trig & ~saw_mode_i & pend;

  xfer_pend #(.NUM_BUF(NUM_BUF)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .buf_wr_i (buf_wr_i),
    .clr_i    (tri_xfer),
    .pend_o   (pend)
  );

  assign xfer_d = tri_xfer | (trig & saw_mode_i);
  assign dt_d   = any_fall | (trig & saw_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_o    <= 1'b0;
      dt_trig_o <= 1'b0;
    end else begin
      xfer_o    <= xfer_d;
      dt_trig_o <= dt_d;
    end
  end

  // trigger bit is write-only in effect
  assign sw_trig_rdata_o = 1'b0;
endmodule

// File: rtl/xfer_ctl_chk.sv
module xfer_ctl_chk #(
  parameter int unsigned NUM_OS  = 3,
  parameter int unsigned NUM_BUF = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               uflow_i,
  input logic               sw_trig_wr_i,
  input logic               sw_trig_wdata_i,
  input logic               tmr_wr_i,
  input logic               tmr_trig_en_i,
  input logic [NUM_BUF-1:0] buf_wr_i,
  input logic               saw_mode_i,
  input logic [NUM_OS-1:0]  os_pulse_i,
  input logic               xfer_o,
  input logic               dt_trig_o
);
  logic [NUM_OS-1:0] os_q;
  logic trig_c, fall_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) os_q <= '0;
    else         os_q <= os_pulse_i;
  end

  assign trig_c = uflow_i | (sw_trig_wr_i & sw_trig_wdata_i) | (tmr_wr_i & tmr_trig_en_i);
  assign fall_c = |(os_q & ~os_pulse_i);

  // R5
  a_r5_saw_every: assert property (@(posedge clk_i) disable iff (!rst_ni)
    saw_mode_i && trig_c |=> xfer_o);

  // R6
  a_r6_fall_dt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_c |=> dt_trig_o);

  // R7
  a_r7_saw_dt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    saw_mode_i && trig_c |=> dt_trig_o);
  a_r7_tri_no_dt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !saw_mode_i && !fall_c |=> !dt_trig_o);

  // R3
  a_r3_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !saw_mode_i && trig_c && $past(!saw_mode_i && trig_c && !(|buf_wr_i)) |=> !xfer_o);

  // R8, R9
  a_r9_no_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_c |=> !xfer_o);

  // R1
  always_comb begin
    if (!rst_ni) a_r1_reset: assert (!xfer_o && !dt_trig_o);
  end
endmodule

bind xfer_ctl_top xfer_ctl_chk #(.NUM_OS(NUM_OS), .NUM_BUF(NUM_BUF)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .uflow_i         (uflow_i),
  .sw_trig_wr_i    (sw_trig_wr_i),
  .sw_trig_wdata_i (sw_trig_wdata_i),
  .tmr_wr_i        (tmr_wr_i),
  .tmr_trig_en_i   (tmr_trig_en_i),
  .buf_wr_i        (buf_wr_i),
  .saw_mode_i      (saw_mode_i),
  .os_pulse_i      (os_pulse_i),
  .xfer_o          (xfer_o),
  .dt_trig_o       (dt_trig_o)
);

// File: tb/sim_xfer_ctl_top.sv
`timescale 1ns/1ps
module sim_xfer_ctl_top;
  localparam int unsigned NOS = 3;
  localparam int unsigned NBUF = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic uflow, sw_wr, sw_wd, sw_rd, tmr_wr, tmr_en, saw, xfer, dt;
  logic [NBUF-1:0] bw;
  logic [NOS-1:0] os;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic m_pend;
  logic [NOS-1:0] m_os;

  always #2.5 clk = ~clk;

  xfer_ctl_top #(.NUM_OS(NOS), .NUM_BUF(NBUF)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .uflow_i(uflow), .sw_trig_wr_i(sw_wr),
    .sw_trig_wdata_i(sw_wd), .sw_trig_rdata_o(sw_rd), .tmr_wr_i(tmr_wr),
    .tmr_trig_en_i(tmr_en), .buf_wr_i(bw), .saw_mode_i(saw),
    .os_pulse_i(os), .xfer_o(xfer), .dt_trig_o(dt)
  );

  function automatic logic f_trig(logic u, logic sw, logic sd, logic tw, logic te);
    return u | (sw & sd) | (tw & te);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic clr_in();
    uflow = 0; sw_wr = 0; sw_wd = 0; tmr_wr = 0; tmr_en = 0; bw = '0;
  endtask

  // one cycle with the current inputs, then compare the registered outputs
  task automatic cyc(string tag);
    logic t, f, ex, ed;
    t  = f_trig(uflow, sw_wr, sw_wd, tmr_wr, tmr_en);
    f  = |(m_os & ~os);
    ex = t & (saw | m_pend);
    ed = f | (saw & t);
    m_pend = (|bw) | (m_pend & ~(t & ~saw));
    m_os = os;
    @(posedge clk); #1;
    chk(tag, "xfer_o", xfer, ex);
    chk(tag, "dt_trig_o", dt, ed);
    chk("R8", "sw_trig_rdata_o", sw_rd, 1'b0);
    clr_in();
  endtask

  initial begin
    clr_in(); saw = 0; os = '0; m_pend = 0; m_os = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "xfer_o reset", xfer, 1'b0);
    chk("R1", "dt_trig_o reset", dt, 1'b0);
    rst_ni = 1'b1;
    cyc("R1");

    // R2: each source transfers fresh buffer contents
    bw = 2'b01; cyc("R2"); uflow = 1; cyc("R2");
    bw = 2'b10; cyc("R2"); sw_wr = 1; sw_wd = 1; cyc("R2");
    bw = 2'b11; cyc("R2"); tmr_wr = 1; tmr_en = 1; cyc("R2");
    // R9, R8: non-triggers leave pending intact
    bw = 2'b01; cyc("R9"); tmr_wr = 1; tmr_en = 0; cyc("R9");
    sw_wr = 1; sw_wd = 0; cyc("R8"); uflow = 1; cyc("R9");
    // R3: only the first trigger moves data
    bw = 2'b10; cyc("R3"); uflow = 1; cyc("R3"); uflow = 1; cyc("R3"); sw_wr = 1; sw_wd = 1; cyc("R3");
    // R4: write and trigger in same cycle, flag clear before
    bw = 2'b01; uflow = 1; cyc("R4"); uflow = 1; cyc("R4");
    // R4: flag set before, write and trigger together
    bw = 2'b01; cyc("R4"); bw = 2'b10; uflow = 1; cyc("R4"); uflow = 1; cyc("R4"); uflow = 1; cyc("R4");
    // R10: all sources at once
    bw = 2'b01; cyc("R10"); uflow = 1; sw_wr = 1; sw_wd = 1; tmr_wr = 1; tmr_en = 1; cyc("R10"); cyc("R10");
    // R7: triangular trigger gives no dead-time strobe
    uflow = 1; cyc("R7");
    // R5/R7: sawtooth
    saw = 1; cyc("R5");
    uflow = 1; cyc("R5"); uflow = 1; cyc("R5"); sw_wr = 1; sw_wd = 1; cyc("R7");
    tmr_wr = 1; tmr_en = 1; cyc("R5"); cyc("R5");
    // R6: falling edges in both modes, rising ignored
    os = 3'b001; cyc("R6"); os = 3'b000; cyc("R6"); cyc("R6");
    saw = 0;
    os = 3'b110; cyc("R6"); cyc("R6"); os = 3'b010; cyc("R6"); os = 3'b000; uflow = 1; cyc("R10"); cyc("R6");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom(32'd7 + i));
      uflow  = (r[2:0] == 3'd0);
      sw_wr  = (r[4:3] == 2'd0); sw_wd = r[5];
      tmr_wr = r[6]; tmr_en = r[7] & r[0];
      bw     = ((r[3:1] == 3'd5) ? NBUF'($urandom) : '0);
      os     = NOS'($urandom);
      if ((i % 200) == 0) saw = ~saw;
      cyc(saw ? "R5" : "R3");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule